// File: doc/BRIEF.md
# Signed Multiply Unit with Overflow Flags

This block is a registered execution unit that multiplies two two's-complement operands at an operand size picked on each request: 8, 16, 32 or 64 bits. Each operand is taken from the low bits of its 64-bit input bus at the chosen size and read as a signed number. The product is always formed at twice the operand size. A form select then decides how much of that product is returned. The widening form returns both halves. The truncating form and the immediate form return only the low half. The immediate form replaces the second register operand with an 8-bit or 32-bit immediate, which is sign-extended before use.

Every result also carries a carry flag and an overflow flag. Both flags are raised when the full product cannot be rebuilt by sign-extending its low operand-size bits, which means significant bits were dropped. A request is presented with `in_valid`. The result, both flags and `out_valid` all appear together one clock later.

A two-state valid tracker drives `out_valid`. `ST_EMPTY` means no result was captured on the last edge, and `ST_FULL` means one was. The tracker takes the transition *accept* (any state to `ST_FULL` when `in_valid` is high) or the transition *drain* (any state to `ST_EMPTY` when `in_valid` is low). Results are held while the tracker is in `ST_EMPTY`.

Top module: `smul_unit`

## Requirements
- R1: The operand size code `op_size` selects N: 0 gives 8 bits, 1 gives 16, 2 gives 32 and 3 gives 64. Each operand is the low N bits of its bus read as two's complement. Bus bits at or above N have no effect on any output.
- R2: The form code `op_form` selects the form: 0 is widening, 1 is truncating, 2 is immediate. Code 3 behaves exactly like code 1.
- R3: In the widening form at N = 16, 32 or 64, `res_lo` holds product bits [N-1:0] and `res_hi` holds product bits [2N-1:N]. Both are zero above bit N-1.
- R4: In the widening form at N = 8, `res_lo[15:0]` holds the whole 16-bit product, `res_lo[63:16]` is zero and `res_hi` is zero.
- R5: In the truncating and immediate forms, `res_lo` holds product bits [N-1:0] zero-extended, and `res_hi` is zero.
- R6: In the immediate form, `imm_wide` = 0 takes `imm[7:0]` and `imm_wide` = 1 takes `imm[31:0]`. The chosen value is sign-extended, and its low N bits, read as signed, form the second operand. `src_b` and unused immediate bits have no effect.
- R7: `cf` and `of` are 1 exactly when the 2N-bit signed product differs from the sign extension of its low N bits. Otherwise both are 0, and the two flags are always equal. The same rule applies in every form.
- R8: The low N bits of `res_lo` equal the low N bits of the unsigned product of the same operand bits.
- R9: `out_valid` is high in the cycle after a cycle with `in_valid` high. Results and flags update on that same edge.
- R10: After an edge with `in_valid` low, `out_valid` is 0 and `res_lo`, `res_hi`, `cf` and `of` keep their previous values.
- R11: While `rst_n` is low and right after it is released, `out_valid`, `res_lo`, `res_hi`, `cf` and `of` are all zero.
- R12: At every size, the most negative value times -1 in the truncating form sets `cf` and `of`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| op_size | input | 2 | Operand size code (0:8, 1:16, 2:32, 3:64) |
| op_form | input | 2 | Form code (0 widening, 1 truncating, 2 immediate, 3 as 1) |
| imm_wide | input | 1 | Immediate width: 0 uses 8 bits, 1 uses 32 bits |
| src_a | input | 64 | First operand bus |
| src_b | input | 64 | Second operand bus (unused in immediate form) |
| imm | input | 32 | Immediate value |
| out_valid | output | 1 | Result present |
| res_lo | output | 64 | Low product half (whole product at 8-bit widening) |
| res_hi | output | 64 | High product half in widening form, else zero |
| cf | output | 1 | Carry flag: significant bits lost |
| of | output | 1 | Overflow flag, equal to `cf` |

## Verification
The hardest situation to reach is a product that sits right at the edge of what N bits can hold. Examples are a 64-bit product of exactly -2^63, which keeps the flags clear, against +2^63, which sets them. Uniform random operands almost never land there, because their products overflow nearly every time. The stimulus therefore shifts each random operand right by a random amount and randomly negates it, which spreads magnitudes across the whole range. Directed cases cover the exact power-of-two boundaries and the most-negative-times-minus-one case at every size.

// File: rtl/smul_pkg.sv
`timescale 1ns/1ps
package smul_pkg;
    localparam int SIZE_CNT = 4;

    typedef enum logic [1:0] {
        SZ8  = 2'd0,
        SZ16 = 2'd1,
        SZ32 = 2'd2,
        SZ64 = 2'd3
    } size_e;

    typedef enum logic [1:0] {
        FM_WIDE  = 2'd0,
        FM_TRUNC = 2'd1,
        FM_IMM   = 2'd2,
        FM_RSVD  = 2'd3
    } form_e;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } vstate_e;
endpackage

// File: rtl/smul_opsel.sv
`timescale 1ns/1ps
module smul_opsel
    import smul_pkg::*;
#(
    parameter int DW = 64,
    parameter int IW = 32
) (
    input  size_e           size_i,
    input  form_e           form_i,
    input  logic            imm_wide_i,
    input  logic [DW-1:0]   a_i,
    input  logic [DW-1:0]   b_i,
    input  logic [IW-1:0]   imm_i,
    output logic [DW-1:0]   a_o,
    output logic [DW-1:0]   b_o
);
    logic [DW-1:0] imm_x;
    logic [DW-1:0] b_raw;
    logic [DW-1:0] a_ext [SIZE_CNT];
    logic [DW-1:0] b_ext [SIZE_CNT];

    // Immediate sign-extended to the full bus first, narrowed per size below
    always_comb begin
        if (imm_wide_i)
            imm_x = {{(DW-IW){imm_i[IW-1]}}, imm_i};
        else
            imm_x = {{(DW-8){imm_i[7]}}, imm_i[7:0]};
        b_raw = (form_i == FM_IMM) ? imm_x : b_i;
    end

    for (genvar g = 0; g < SIZE_CNT; g++) begin : g_sz
        localparam int W = 8 << g;
        if (W >= DW) begin : g_full
            assign a_ext[g] = a_i;
            assign b_ext[g] = b_raw;
        end else begin : g_part
            assign a_ext[g] = {{(DW-W){a_i[W-1]}}, a_i[W-1:0]};
            assign b_ext[g] = {{(DW-W){b_raw[W-1]}}, b_raw[W-1:0]};
        end
    end

    assign a_o = a_ext[size_i];
    assign b_o = b_ext[size_i];
endmodule

// File: rtl/smul_core.sv
`timescale 1ns/1ps
module smul_core
    import smul_pkg::*;
#(
    parameter int DW = 64
) (
    input  size_e          size_i,
    input  logic [DW-1:0]  a_i,
    input  logic [DW-1:0]  b_i,
    output logic [DW-1:0]  lo_o,
    output logic [DW-1:0]  hi_o,
    output logic           ovf_o
);
    localparam int PW = 2 * DW;

    logic signed [PW-1:0] sa;
    logic signed [PW-1:0] sb;
    logic signed [PW-1:0] prod;
    logic [DW-1:0] lo_v [SIZE_CNT];
    logic [DW-1:0] hi_v [SIZE_CNT];
    logic [SIZE_CNT-1:0] ovf_v;

    assign sa   = {{DW{a_i[DW-1]}}, a_i};
    assign sb   = {{DW{b_i[DW-1]}}, b_i};
    assign prod = sa * sb;

    for (genvar g = 0; g < SIZE_CNT; g++) begin : g_sz
        localparam int W = 8 << g;
        logic [PW-W:0] top_bits;
        assign top_bits = prod[PW-1:W-1];
        // Lost bits: everything from bit W-1 upward must be one repeated sign
        assign ovf_v[g] = ~((&top_bits) | (~|top_bits));
        if (W >= DW) begin : g_full
            assign lo_v[g] = prod[DW-1:0];
            assign hi_v[g] = prod[PW-1:DW];
        end else begin : g_part
            assign lo_v[g] = {{(DW-W){1'b0}}, prod[W-1:0]};
            assign hi_v[g] = {{(DW-W){1'b0}}, prod[2*W-1:W]};
        end
    end

    assign lo_o  = lo_v[size_i];
    assign hi_o  = hi_v[size_i];
    assign ovf_o = ovf_v[size_i];
endmodule

// File: rtl/smul_unit.sv
`timescale 1ns/1ps
module smul_unit
    import smul_pkg::*;
#(
    parameter int DW = 64,
    parameter int IW = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_valid,
    input  logic [1:0]     op_size,
    input  logic [1:0]     op_form,
    input  logic           imm_wide,
    input  logic [DW-1:0]  src_a,
    input  logic [DW-1:0]  src_b,
    input  logic [IW-1:0]  imm,
    output logic           out_valid,
    output logic [DW-1:0]  res_lo,
    output logic [DW-1:0]  res_hi,
    output logic           cf,
    output logic           of
);
    size_e   size_s;
    form_e   form_s;
    vstate_e st_q, st_d;
    logic [DW-1:0] opa, opb, lo_c, hi_c, lo_d, hi_d;
    logic          ovf_c;

    assign size_s = size_e'(op_size);
    assign form_s = form_e'(op_form);

    smul_opsel #(.DW(DW), .IW(IW)) u_opsel (
        .size_i(size_s), .form_i(form_s), .imm_wide_i(imm_wide),
        .a_i(src_a), .b_i(src_b), .imm_i(imm),
        .a_o(opa), .b_o(opb)
    );

    smul_core #(.DW(DW)) u_core (
        .size_i(size_s), .a_i(opa), .b_i(opb),
        .lo_o(lo_c), .hi_o(hi_c), .ovf_o(ovf_c)
    );

    // Result shaping by form
    always_comb begin
        unique case (form_s)
            FM_WIDE: begin
                if (size_s == SZ8) begin
                    lo_d = {{(DW-16){1'b0}}, hi_c[7:0], lo_c[7:0]};
                    hi_d = '0;
                end else begin
                    lo_d = lo_c;
                    hi_d = hi_c;
                end
            end
            FM_TRUNC, FM_IMM, FM_RSVD: begin
                lo_d = lo_c;
                hi_d = '0;
            end
        endcase
    end

    // Valid tracker: accept / drain
    always_comb begin
        unique case (st_q)
            ST_EMPTY: st_d = in_valid ? ST_FULL : ST_EMPTY;
            ST_FULL:  st_d = in_valid ? ST_FULL : ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_EMPTY;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_lo <= '0;
            res_hi <= '0;
            cf     <= 1'b0;
            of     <= 1'b0;
        end else if (in_valid) begin
            res_lo <= lo_d;
            res_hi <= hi_d;
            cf     <= ovf_c;
            of     <= ovf_c;
        end
    end

    assign out_valid = (st_q == ST_FULL);

    // R7
    flag_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cf == of);

    // R9
    valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(in_valid && rst_n));

    // R5
    hi_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && form_s != FM_WIDE) |=> (res_hi == '0));

    // R4
    wide8_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && form_s == FM_WIDE && size_s == SZ8)
            |=> (res_hi == '0 && res_lo[DW-1:16] == '0));

    // R7
    wide64_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && form_s == FM_WIDE && size_s == SZ64)
            |=> (cf == (res_hi != {DW{res_lo[DW-1]}})));

    // R10
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(res_lo) && $stable(res_hi) && $stable(cf) && !out_valid));
endmodule

// File: tb/sim_smul_unit.sv
`timescale 1ns/1ps
module sim_smul_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  op_size = '0;
    logic [1:0]  op_form = '0;
    logic        imm_wide = 1'b0;
    logic [63:0] src_a = '0;
    logic [63:0] src_b = '0;
    logic [31:0] imm = '0;
    logic        out_valid, cf, of;
    logic [63:0] res_lo, res_hi;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    smul_unit u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_size(op_size),
        .op_form(op_form), .imm_wide(imm_wide), .src_a(src_a), .src_b(src_b),
        .imm(imm), .out_valid(out_valid), .res_lo(res_lo), .res_hi(res_hi),
        .cf(cf), .of(of)
    );

    function automatic logic [63:0] sx(logic [63:0] v, int n);
        logic signed [63:0] t;
        t = v << (64 - n);
        return t >>> (64 - n);
    endfunction

    function automatic logic [63:0] msk(int n);
        return (n == 64) ? '1 : ((64'd1 << n) - 64'd1);
    endfunction

    task automatic model(input logic [1:0] sz, input logic [1:0] fm, input logic iw,
                         input logic [63:0] a, input logic [63:0] b, input logic [31:0] im,
                         output logic [63:0] elo, output logic [63:0] ehi, output logic ef);
        int n;
        logic [63:0] ea, eb, lo;
        logic signed [127:0] pa, pb, p, lo128;
        n  = 8 << sz;
        ea = sx(a, n);
        if (fm == 2'd2) eb = sx(iw ? sx({32'd0, im}, 32) : sx({56'd0, im[7:0]}, 8), n);
        else            eb = sx(b, n);
        pa = {{64{ea[63]}}, ea};
        pb = {{64{eb[63]}}, eb};
        p  = pa * pb;
        lo = p[63:0] & msk(n);
        lo128 = {{64{sx(lo, n)}}, sx(lo, n)};
        lo128 = {{64{lo128[63]}}, lo128[63:0]};
        ef = (p != lo128);
        if (fm == 2'd0 && n == 8) begin
            elo = {48'd0, p[15:0]};
            ehi = '0;
        end else if (fm == 2'd0) begin
            elo = lo;
            ehi = (n == 64) ? p[127:64] : (p[127:0] >> n) & msk(n);
        end else begin
            elo = lo;
            ehi = '0;
        end
    endtask

    task automatic chk(input bit ok, input string rq, input logic [127:0] act, input logic [127:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", rq, act, exp);
        end
    endtask

    // Drive one request at a falling edge, sample at the next falling edge
    task automatic run(input logic [1:0] sz, input logic [1:0] fm, input logic iw,
                       input logic [63:0] a, input logic [63:0] b, input logic [31:0] im);
        logic [63:0] elo, ehi, ulo;
        logic ef;
        string lrq;
        model(sz, fm, iw, a, b, im, elo, ehi, ef);
        op_size = sz; op_form = fm; imm_wide = iw;
        src_a = a; src_b = b; imm = im; in_valid = 1'b1;
        @(negedge clk);
        if (fm == 2'd0 && sz == 2'd0) lrq = "R4 lo";
        else if (fm == 2'd0)          lrq = "R3 lo";
        else if (fm == 2'd2)          lrq = "R6 lo";
        else                          lrq = "R5 lo";
        chk(out_valid == 1'b1, "R9 valid", {127'd0, out_valid}, 128'd1);
        chk(res_lo == elo, lrq, {64'd0, res_lo}, {64'd0, elo});
        chk(res_hi == ehi, (fm == 2'd0) ? "R3 hi" : "R5 hi", {64'd0, res_hi}, {64'd0, ehi});
        chk(cf == ef && of == ef, "R7 flags", {126'd0, cf, of}, {126'd0, ef, ef});
        if (fm != 2'd2) begin
            ulo = (a * b) & msk(8 << sz);
            chk((res_lo & msk(8 << sz)) == ulo, "R8 unsigned low",
                {64'd0, res_lo & msk(8 << sz)}, {64'd0, ulo});
        end
    endtask

    function automatic logic [63:0] rnd_op();
        logic [63:0] v;
        v = {$urandom, $urandom} >> ($urandom % 64);
        if ($urandom % 2) v = -v;
        return v;
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [63:0] keep_lo;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(out_valid == 0 && res_lo == 0 && res_hi == 0 && cf == 0 && of == 0,
            "R11 reset", {res_lo, res_hi}, 128'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 0 && res_lo == 0 && cf == 0, "R11 after release",
            {127'd0, out_valid}, 128'd0);

        // R4 widening at 8 bits
        run(2'd0, 2'd0, 0, 64'h7F, 64'h7F, 32'd0);
        run(2'd0, 2'd0, 0, 64'h80, 64'h80, 32'd0);
        // R12 most negative times -1 at every size
        for (int s = 0; s < 4; s++) begin
            run(2'(s), 2'd1, 0, 64'd1 << ((8 << s) - 1), '1, 32'd0);
            chk(cf == 1 && of == 1, "R12 min*-1", {126'd0, cf, of}, 128'd3);
        end
        // R7 boundaries at 64 bits
        run(2'd3, 2'd1, 0, -(64'd1 << 31), 64'd1 << 32, 32'd0);
        chk(cf == 0, "R7 fits -2^63", {127'd0, cf}, 128'd0);
        run(2'd3, 2'd1, 0, 64'd1 << 31, 64'd1 << 32, 32'd0);
        chk(cf == 1, "R7 exceeds 2^63", {127'd0, cf}, 128'd1);
        run(2'd3, 2'd0, 0, '1, 64'd5, 32'd0);
        run(2'd2, 2'd0, 0, 64'h8000_0000, 64'h8000_0000, 32'd0);
        // R6 immediates
        run(2'd3, 2'd2, 1, 64'd3, 64'h1234, 32'h8000_0000);
        run(2'd1, 2'd2, 0, 64'd7, 64'hFFFF, 32'hABCD_12FF);
        // R1 upper bus bits ignored
        run(2'd1, 2'd1, 0, 64'hDEAD_BEEF_0000_0003, 64'hFFFF_FFFF_1234_FFFE, 32'd0);
        chk(res_lo == 64'hFFFA, "R1 upper ignored", {64'd0, res_lo}, 128'hFFFA);
        // R2 reserved form acts as truncating
        run(2'd2, 2'd3, 0, 64'h1_0001_0000, 64'h3_0003_0000, 32'd0);
        chk(res_hi == 0 && res_lo == 0, "R2 code 3", {res_hi, res_lo}, 128'd0);

        // R10 hold while idle
        keep_lo = res_lo;
        in_valid = 1'b0; src_a = 64'h55; src_b = 64'h77; op_form = 2'd0;
        @(negedge clk);
        chk(out_valid == 0 && res_lo == keep_lo, "R10 hold",
            {63'd0, out_valid, res_lo}, {64'd0, keep_lo});

        // Constrained random
        for (int i = 0; i < 400; i++) begin
            run(2'($urandom % 4), 2'($urandom % 4), 1'($urandom % 2),
                rnd_op(), rnd_op(), $urandom);
        end

        in_valid = 1'b0;
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule